// File: doc/BRIEF.md
# Manchester Line Decoder with Nibble Output

This block sits behind the clock-recovery stage of a 10 Mb/s receiver. It takes the line as a stream of half-bit samples, one sample on each cycle where `half_bit_strobe` is high (the 20 MHz rate). It pairs the samples into bit cells and finds cell alignment from the alternating preamble. Once locked, it packs the decoded bits into 4-bit words and presents each word with a one-cycle receive clock enable (the 2.5 MHz rate). It marks frame validity with `rx_dv` and flags coding violations with `rx_er`. A frame ends when the line holds a run of low half-bits, when the idle terminator arrives, or when the upstream carrier indication drops.

The output is a pushed stream with no back-pressure. A word is valid in the cycle where `rx_clk_en` is high, and no ready input exists. The consumer must take every word in that cycle, because the line rate cannot be stalled. `rxd` has no meaning while `rx_dv` is low.

Top module: `mdec_rx_nibble`

## Requirements
- R1: A cell whose half-bits are low then high decodes as 1, and one that is high then low decodes as 0. Four decoded bits form one word, with the earliest bit on `rxd[0]`. The word appears together with a `rx_clk_en` pulse that lasts one clock cycle.
- R2: `rx_dv` stays low until the hunt has seen four consecutive valid cells with alternating values. It then rises together with the first `rx_clk_en` pulse of the frame.
- R3: The four cells used for locking are not delivered. With the preamble aligned to the strobe pairs (first preamble bit 1), the first delivered word is preamble bits 4..7, which gives `rxd` = 4'h5.
- R4: While hunting, an invalid cell (two equal half-bits) shifts the pairing by one half-bit and restarts the count. A valid cell that repeats the previous bit also restarts the count. With one extra high half-bit placed before the preamble, the lock ends on preamble bit 4 and the first word is bits 5..8 (4'hA).
- R5: While `rx_dv` is high, a word that contains any invalid cell is delivered with `rx_er` high. A word with no invalid cell is delivered with `rx_er` low.
- R6: Eight consecutive low half-bits inside a frame end it. `rx_dv` falls one clock after the ending strobe, and any partial word is discarded.
- R7: The half-bit pattern 1,1,1,1,0,0,0,0 inside a frame ends it in the same way. When a word would complete on the same strobe, the end takes priority over that word.
- R8: A low `carrier_ok` clears `rx_dv` and `rx_er` on the next clock and returns the decoder to the hunt.
- R9: After reset, `rx_dv`, `rx_er`, `rx_clk_en` and `rxd` are all zero.
- R10: `rx_clk_en` pulses only while `rx_dv` is high, and `rx_er` is never high while `rx_dv` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_bit_strobe | input | 1 | High for one cycle when a new half-bit sample is present |
| half_bit_value | input | 1 | Half-bit sample level, read when the strobe is high |
| carrier_ok | input | 1 | Upstream indication that a valid carrier is present |
| rxd | output | 4 | Decoded word, earliest bit in bit 0 |
| rx_clk_en | output | 1 | One-cycle pulse marking a new word on rxd |
| rx_dv | output | 1 | Frame data valid |
| rx_er | output | 1 | Coding violation inside the current word |

## Verification
Each word, its `rx_er` and the rise of `rx_dv` become visible one clock after the strobe that carries the second half of the word's fourth cell. An end of frame or a carrier drop shows on `rx_dv` one clock after its strobe or its falling edge. The bench changes inputs on falling edges, leaves four idle cycles after each strobe, and samples the outputs on falling edges only. It records every `rx_clk_en` word as it appears. After each frame it compares the recorded words in order with a list built from the bits it sent. It checks `rx_dv` after the final ending half-bit or one cycle after a carrier drop, and checks that `rx_dv` is still low just before the eighth preamble bit.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  typedef enum logic {ST_HUNT, ST_FRAME} mdec_state_e;
endpackage

// File: rtl/mdec_cell_align.sv
// Pairs half-bit samples into bit cells; may slip the pairing by one half-bit while hunting.
module mdec_cell_align (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic slip_en,
  input  logic strobe,
  input  logic half_val,
  output logic cell_vld,
  output logic cell_bit,
  output logic cell_bad
);
  logic ph_q;
  logic first_q;

  assign cell_vld = strobe & ph_q;
  assign cell_bit = half_val;
  assign cell_bad = (first_q == half_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= 1'b0;
      first_q <= 1'b0;
    end else if (clear) begin
      ph_q    <= 1'b0;
    end else if (strobe) begin
      if (!ph_q) begin
        first_q <= half_val;
        ph_q    <= 1'b1;
      end else if (slip_en && cell_bad) begin
        first_q <= half_val;   // treat this sample as the start of a new cell
        ph_q    <= 1'b1;
      end else begin
        ph_q    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdec_end_detect.sv
// Watches the half-bit stream for a run of low samples or the idle terminator pattern.
module mdec_end_detect #(
  parameter int          ZRUN   = 8,
  parameter int          TERM_W = 8,
  parameter logic [TERM_W-1:0] TERM = 8'b1111_0000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic strobe,
  input  logic half_val,
  output logic end_hit
);
  localparam int ZCW = $clog2(ZRUN + 1);

  logic [TERM_W-1:0] hist_q;
  logic [ZCW-1:0]    zcnt_q;
  logic              zrun_hit;
  logic              term_hit;

  assign zrun_hit = ~half_val & (zcnt_q >= ZCW'(ZRUN - 1));
  assign term_hit = ({hist_q[TERM_W-2:0], half_val} == TERM);
  assign end_hit  = strobe & (zrun_hit | term_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      zcnt_q <= '0;
    end else if (clear) begin
      hist_q <= '0;
      zcnt_q <= '0;
    end else if (strobe) begin
      hist_q <= {hist_q[TERM_W-2:0], half_val};
      if (half_val)
        zcnt_q <= '0;
      else if (zcnt_q < ZCW'(ZRUN - 1))
        zcnt_q <= zcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdec_nibble_pack.sv
// Packs decoded bits into words, earliest bit in bit 0, and owns all output flags.
module mdec_nibble_pack #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             kill,
  input  logic             take,
  input  logic             bit_in,
  input  logic             bad_in,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_clk_en,
  output logic             rx_dv,
  output logic             rx_er
);
  localparam int CW = $clog2(NIB_W);

  logic [NIB_W-1:0] sr_q;
  logic [CW-1:0]    cnt_q;
  logic             err_q;
  logic             emit;

  assign emit = active & take & ~kill & (cnt_q == CW'(NIB_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q      <= '0;
      cnt_q     <= '0;
      err_q     <= 1'b0;
      rxd       <= '0;
      rx_clk_en <= 1'b0;
      rx_dv     <= 1'b0;
      rx_er     <= 1'b0;
    end else begin
      rx_clk_en <= emit;
      if (kill || !active) begin
        cnt_q <= '0;
        err_q <= 1'b0;
        rx_dv <= 1'b0;
        rx_er <= 1'b0;
      end else if (take) begin
        if (emit) begin
          rxd   <= {bit_in, sr_q[NIB_W-1:1]};
          rx_er <= err_q | bad_in;
          rx_dv <= 1'b1;
          cnt_q <= '0;
          err_q <= 1'b0;
        end else begin
          sr_q  <= {bit_in, sr_q[NIB_W-1:1]};
          cnt_q <= cnt_q + 1'b1;
          err_q <= err_q | bad_in;
        end
      end
    end
  end

  AST_CLKEN_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n) rx_clk_en |-> rx_dv); // R10
  AST_ER_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n) rx_er |-> rx_dv); // R10
  AST_DV_RISES_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_dv) |-> rx_clk_en); // R2
  AST_KILL_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) kill |=> (!rx_dv && !rx_er)); // R8
endmodule

// File: rtl/mdec_rx_nibble.sv
module mdec_rx_nibble
  import mdec_pkg::*;
#(
  parameter int LOCK_BITS = 4,
  parameter int ZRUN      = 8,
  parameter int NIB_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_bit_strobe,
  input  logic             half_bit_value,
  input  logic             carrier_ok,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_clk_en,
  output logic             rx_dv,
  output logic             rx_er
);
  localparam int PW = $clog2(LOCK_BITS + 1);

  mdec_state_e   state_q;
  logic [PW-1:0] pre_cnt_q;
  logic          last_bit_q;
  logic          cell_vld, cell_bit, cell_bad;
  logic          end_hit, kill, in_frame;

  assign in_frame = (state_q == ST_FRAME);
  assign kill     = ~carrier_ok | (in_frame & end_hit);

  mdec_cell_align u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (~carrier_ok),
    .slip_en  (~in_frame),
    .strobe   (half_bit_strobe),
    .half_val (half_bit_value),
    .cell_vld (cell_vld),
    .cell_bit (cell_bit),
    .cell_bad (cell_bad)
  );

  mdec_end_detect #(.ZRUN(ZRUN)) u_end (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (~carrier_ok),
    .strobe   (half_bit_strobe),
    .half_val (half_bit_value),
    .end_hit  (end_hit)
  );

  mdec_nibble_pack #(.NIB_W(NIB_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (in_frame),
    .kill      (kill),
    .take      (cell_vld),
    .bit_in    (cell_bit),
    .bad_in    (cell_bad),
    .rxd       (rxd),
    .rx_clk_en (rx_clk_en),
    .rx_dv     (rx_dv),
    .rx_er     (rx_er)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HUNT;
      pre_cnt_q  <= '0;
      last_bit_q <= 1'b0;
    end else if (!carrier_ok) begin
      state_q   <= ST_HUNT;
      pre_cnt_q <= '0;
    end else begin
      case (state_q)
        ST_HUNT: begin
          if (cell_vld) begin
            last_bit_q <= cell_bit;
            if (cell_bad)
              pre_cnt_q <= '0;
            else if (pre_cnt_q != '0 && cell_bit == last_bit_q)
              pre_cnt_q <= PW'(1);
            else if (pre_cnt_q == PW'(LOCK_BITS - 1)) begin
              state_q   <= ST_FRAME;
              pre_cnt_q <= '0;
            end else
              pre_cnt_q <= pre_cnt_q + 1'b1;
          end
        end
        default: begin
          if (end_hit) state_q <= ST_HUNT;
        end
      endcase
    end
  end

  AST_DV_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) rx_dv |-> in_frame); // R2
  AST_END_DROPS_DV: assert property (@(posedge clk) disable iff (!rst_n) (in_frame && end_hit) |=> !rx_dv); // R6
  AST_CARRIER_DROPS_DV: assert property (@(posedge clk) disable iff (!rst_n) !carrier_ok |=> !rx_dv); // R8
  AST_WORD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_clk_en) |-> $past(half_bit_strobe)); // R1
endmodule

// File: tb/tb_mdec_rx_nibble.sv
module tb_mdec_rx_nibble;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic hv = 1'b0;
  logic carrier = 1'b0;
  logic [3:0] rxd;
  logic clken, dv, er;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;
  logic [5:0] got_q[$];

  always #5 clk = ~clk;

  mdec_rx_nibble dut (
    .clk(clk), .rst_n(rst_n), .half_bit_strobe(strobe), .half_bit_value(hv),
    .carrier_ok(carrier), .rxd(rxd), .rx_clk_en(clken), .rx_dv(dv), .rx_er(er)
  );

  always @(negedge clk) if (clken) got_q.push_back({dv, er, rxd});

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic send_half(bit v);
    @(negedge clk); hv = v; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bit(bit b);  // 1 -> low,high ; 0 -> high,low
    send_half(~b);
    send_half(b);
  endtask

  // kind: 0 zero run, 1 idle terminator, 2 carrier drop
  task automatic run_frame(bit offset, int ndata, int viol, int kind);
    logic [3:0] exp_n[$];
    bit exp_e[$];
    logic [3:0] d;
    int pre;
    got_q.delete();
    carrier = 1'b1;
    repeat (3) @(negedge clk);
    if (offset) send_half(1'b1);
    pre = offset ? 9 : 8;
    for (int i = 0; i < pre; i++) begin
      if (!offset && i == 7) chk(dv == 1'b0, "R2 dv before first word", int'(dv), 0);
      send_bit(~i[0]);
    end
    exp_n.push_back(offset ? 4'hA : 4'h5);
    exp_e.push_back(1'b0);
    for (int n = 0; n < ndata; n++) begin
      d = 4'($urandom);
      exp_n.push_back(d);
      exp_e.push_back(n == viol);
      for (int b = 0; b < 4; b++) begin
        if (n == viol && b == 1) begin
          bit vv;
          vv = 1'($urandom);
          send_half(vv);
          send_half(vv);
        end else begin
          send_bit(d[b]);
        end
      end
    end
    if (kind == 0) begin
      repeat (8) send_half(1'b0);
      chk(dv == 1'b0, "R6 zero run ends frame", int'(dv), 0);
    end else if (kind == 1) begin
      send_half(1); send_half(1); send_half(1); send_half(1);
      send_half(0); send_half(0); send_half(0); send_half(0);
      chk(dv == 1'b0, "R7 terminator ends frame", int'(dv), 0);
    end else begin
      @(negedge clk); carrier = 1'b0;
      @(negedge clk);
      chk(dv == 1'b0 && er == 1'b0, "R8 carrier drop clears flags", int'({dv, er}), 0);
    end
    chk(got_q.size() == exp_n.size(), "R1 word count", got_q.size(), exp_n.size());
    for (int i = 0; i < got_q.size() && i < exp_n.size(); i++) begin
      chk(got_q[i][5] == 1'b1, "R10 dv with clk_en", int'(got_q[i][5]), 1);
      chk(got_q[i][4] == exp_e[i], "R5 error flag", int'(got_q[i][4]), int'(exp_e[i]));
      if (!exp_e[i]) begin
        if (i == 0)
          chk(got_q[i][3:0] == exp_n[i], offset ? "R4 first word after slip" : "R3 first word",
              int'(got_q[i][3:0]), int'(exp_n[i]));
        else
          chk(got_q[i][3:0] == exp_n[i], "R1 data word", int'(got_q[i][3:0]), int'(exp_n[i]));
      end
    end
    carrier = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rxd, clken, dv, er} == 7'd0, "R9 reset state", int'({rxd, clken, dv, er}), 0);
    run_frame(1'b0, 4, -1, 0);
    run_frame(1'b1, 3, -1, 1);
    run_frame(1'b0, 3, 1, 0);
    run_frame(1'b0, 3, 2, 2);
    run_frame(1'b1, 2, 0, 1);
    for (int k = 0; k < 20; k++) begin
      int nd;
      nd = 1 + int'($urandom % 6);
      run_frame(1'($urandom), nd, ($urandom % 3 == 0) ? int'($urandom % nd) : -1,
                int'($urandom % 3));
    end
    summary();
  end
endmodule